// File: doc/BRIEF.md
# Floating-Point Exponent and Mantissa Splitter

This combinational unit takes one single-precision floating-point word and a 3-bit operation code. It returns one of two kinds of result. The first is a rescaled copy of the significand, still a float. The second is a signed 32-bit integer derived from the exponent. These are the argument-reduction steps that sit in front of reciprocal, square-root, reciprocal-square-root and logarithm evaluation. A flag output tells the consumer which kind of result is on the bus.

The input is read as m·2^e, where m lies in [1,2) and e is the biased exponent minus the bias (127). Subnormal inputs are first flushed to a zero of the same sign. Zero, infinity and NaN take a fixed path. Float-result operations pass such an input through unchanged. Integer-result operations return 0 for it.

For the logarithm split, the value is written as x1·2^s with x1 in [0.75, 1.5). Halving is used only when m is at least 1.5.

Top module: `fxs_unit`

## Requirements
- R1: Opcodes 0, 1 and 2 give a float result with `is_int_o`=0. Opcodes 3 to 6 give an integer result with `is_int_o`=1. Opcode 7 is reserved: it returns 0 with `is_int_o`=1.
- R2: Opcode 0 (reciprocal significand), for a normal input: the result keeps the input sign and the 23-bit fraction, and sets the exponent field (bits 30:23) to 126. The value is m·2^-1.
- R3: Opcode 1 (square-root significand), for a normal input: the result keeps sign and fraction. The exponent field is 125 when e is even (biased field odd) and 126 when e is odd, so the magnitude lies in [0.25, 1).
- R4: Opcode 2 (log significand), for a normal input: the result keeps sign and fraction. The exponent field is 126 when fraction bit 22 is 1 (m ≥ 1.5) and 127 otherwise.
- R5: Opcode 3 (reciprocal exponent), for a normal input: the result is the two's-complement integer −e−1.
- R6: Opcode 4 (square-root exponent), for a normal input: the result is floor(e/2)+1, with the floor rounding toward minus infinity for negative e.
- R7: Opcode 5 (reciprocal-square-root exponent), for a normal input: the result is −floor(e/2)−1.
- R8: Opcode 6 (log exponent), for a normal input: the result is e+1 when fraction bit 22 is 1 and e otherwise. It pairs with R4, so that x1·2^s equals the input.
- R9: A zero (exponent field 0 and fraction 0) or a special value (exponent field 255, which covers infinity and NaN) takes a fixed path. Opcodes 0 to 2 return the input word unchanged. Opcodes 3 to 6 return 0.
- R10: A subnormal input (exponent field 0 and fraction non-zero) is treated as a zero of the same sign. Opcodes 0 to 2 return only the sign bit in bit 31, with all other bits 0. Opcodes 3 to 6 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Single-precision operand |
| op_i | input | 3 | Operation select (see R1) |
| result_o | output | 32 | Float word or signed integer result |
| is_int_o | output | 1 | 1 when `result_o` holds an integer |

## Verification
The bench targets the exponent extremes: the smallest normal input (e = −126) and the largest finite input (e = 127). A floor written as truncating division would return floor(e/2) one too high for negative odd exponents. A bias error would shift every integer result.

The bench feeds subnormals of both signs. A design that skipped the flush would leak fraction bits into a float result, or derive an exponent of −127 for them.

Values just below and at m = 1.5 exercise the log split. A wrong threshold would break the pairing of x1 and s.

Infinity, NaN and both zeros confirm the pass-through and zero-integer paths. These would otherwise produce bogus scaled values.

// File: rtl/fxs_pkg.sv
package fxs_pkg;

  typedef enum logic [2:0] {
    OP_RCP_MANT  = 3'd0,
    OP_SQRT_MANT = 3'd1,
    OP_LOG_MANT  = 3'd2,
    OP_RCP_EXP   = 3'd3,
    OP_SQRT_EXP  = 3'd4,
    OP_RSQ_EXP   = 3'd5,
    OP_LOG_EXP   = 3'd6,
    OP_RSVD      = 3'd7
  } fxs_op_e;

  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_NORMAL  = 2'd1,
    CLS_SPECIAL = 2'd2
  } fxs_cls_e;

endpackage

// File: rtl/fxs_classify.sv
module fxs_classify
  import fxs_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input  logic [DATA_W-1:0] word_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  bexp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [DATA_W-1:0] flushed_o,
  output fxs_cls_e          cls_o
);

  logic [EXP_W-1:0]  raw_exp;
  logic [FRAC_W-1:0] raw_frac;
  logic              exp_zero;
  logic              exp_full;

  assign raw_exp  = word_i[DATA_W-2 -: EXP_W];
  assign raw_frac = word_i[FRAC_W-1:0];
  assign exp_zero = (raw_exp == '0);
  assign exp_full = (raw_exp == '1);

  always_comb begin
    sign_o = word_i[DATA_W-1];
    bexp_o = raw_exp;
    frac_o = exp_zero ? '0 : raw_frac;
    flushed_o = {sign_o, bexp_o, frac_o};
    if (exp_zero)      cls_o = CLS_ZERO;
    else if (exp_full) cls_o = CLS_SPECIAL;
    else               cls_o = CLS_NORMAL;
  end

endmodule

// File: rtl/fxs_mant_scale.sv
module fxs_mant_scale
  import fxs_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int DATA_W = 1 + EXP_W + FRAC_W,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
  input  fxs_op_e           op_i,
  input  fxs_cls_e          cls_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  bexp_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [DATA_W-1:0] flushed_i,
  output logic [DATA_W-1:0] mant_o
);

  localparam logic [EXP_W-1:0] EXP_ONE     = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_HALF    = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] EXP_QUARTER = EXP_W'(BIAS - 2);
  localparam logic             BIAS_LSB    = EXP_ONE[0];

  logic             e_odd;
  logic             upper_half;
  logic [EXP_W-1:0] tgt_exp;

  // unbiased exponent parity = biased lsb xor bias lsb
  assign e_odd      = bexp_i[0] ^ BIAS_LSB;
  assign upper_half = frac_i[FRAC_W-1];

  always_comb begin
    unique case (op_i)
      OP_SQRT_MANT: tgt_exp = e_odd ? EXP_HALF : EXP_QUARTER;
      OP_LOG_MANT:  tgt_exp = upper_half ? EXP_HALF : EXP_ONE;
      default:      tgt_exp = EXP_HALF;
    endcase
  end

  always_comb begin
    if (cls_i == CLS_NORMAL) mant_o = {sign_i, tgt_exp, frac_i};
    else                     mant_o = flushed_i;
  end

endmodule

// File: rtl/fxs_exp_calc.sv
module fxs_exp_calc
  import fxs_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int DATA_W = 1 + EXP_W + FRAC_W,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
  localparam int EW     = EXP_W + 2
) (
  input  fxs_op_e           op_i,
  input  fxs_cls_e          cls_i,
  input  logic [EXP_W-1:0]  bexp_i,
  input  logic              upper_half_i,
  output logic [DATA_W-1:0] int_o
);

  localparam logic signed [EW-1:0] BIAS_S = EW'(BIAS);
  localparam logic signed [EW-1:0] ONE_S  = EW'(1);
  localparam logic signed [EW-1:0] ZERO_S = '0;

  logic signed [EW-1:0] e_s;
  logic signed [EW-1:0] half_s;
  logic signed [EW-1:0] val_s;

  assign e_s    = $signed({2'b00, bexp_i}) - BIAS_S;
  assign half_s = e_s >>> 1;

  always_comb begin
    unique case (op_i)
      OP_RCP_EXP:  val_s = -e_s - ONE_S;
      OP_SQRT_EXP: val_s = half_s + ONE_S;
      OP_RSQ_EXP:  val_s = -half_s - ONE_S;
      OP_LOG_EXP:  val_s = e_s + (upper_half_i ? ONE_S : ZERO_S);
      default:     val_s = ZERO_S;
    endcase
  end

  always_comb begin
    if (cls_i == CLS_NORMAL) int_o = {{(DATA_W-EW){val_s[EW-1]}}, val_s};
    else                     int_o = '0;
  end

endmodule

// File: rtl/fxs_unit.sv
module fxs_unit
  import fxs_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              is_int_o
);

  fxs_op_e           op;
  fxs_cls_e          cls;
  logic              sign;
  logic [EXP_W-1:0]  bexp;
  logic [FRAC_W-1:0] frac;
  logic [DATA_W-1:0] flushed;
  logic [DATA_W-1:0] mant_res;
  logic [DATA_W-1:0] int_res;
  logic              float_kind;

  assign op = fxs_op_e'(op_i);

  fxs_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_classify (
    .word_i    (operand_i),
    .sign_o    (sign),
    .bexp_o    (bexp),
    .frac_o    (frac),
    .flushed_o (flushed),
    .cls_o     (cls)
  );

  fxs_mant_scale #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_mant (
    .op_i      (op),
    .cls_i     (cls),
    .sign_i    (sign),
    .bexp_i    (bexp),
    .frac_i    (frac),
    .flushed_i (flushed),
    .mant_o    (mant_res)
  );

  fxs_exp_calc #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_exp (
    .op_i         (op),
    .cls_i        (cls),
    .bexp_i       (bexp),
    .upper_half_i (frac[FRAC_W-1]),
    .int_o        (int_res)
  );

  always_comb begin
    unique case (op)
      OP_RCP_MANT, OP_SQRT_MANT, OP_LOG_MANT: float_kind = 1'b1;
      default:                                float_kind = 1'b0;
    endcase
    is_int_o = ~float_kind;
    result_o = float_kind ? mant_res : int_res;
  end

endmodule

// File: rtl/fxs_unit_chk.sv
module fxs_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input logic [DATA_W-1:0] operand_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              is_int_o
);

  logic [EXP_W-1:0] in_exp;
  logic [EXP_W-1:0] out_exp;
  logic             in_normal;

  assign in_exp    = operand_i[DATA_W-2 -: EXP_W];
  assign out_exp   = result_o[DATA_W-2 -: EXP_W];
  assign in_normal = (in_exp != '0) && (in_exp != '1);

  always_comb begin
    p_kind_flag_r1: assert (is_int_o == (op_i >= 3'd3))
      else $error("kind flag wrong for op %0d", op_i);
    p_rsvd_zero_r1: assert (!(op_i == 3'd7) || result_o == '0)
      else $error("reserved op result not zero");
    p_sign_kept_r2: assert (is_int_o || result_o[DATA_W-1] == operand_i[DATA_W-1])
      else $error("float result sign changed");
    p_rcp_mant_exp_r2: assert (!(op_i == 3'd0 && in_normal) || out_exp == EXP_W'((1 << (EXP_W-1)) - 2))
      else $error("reciprocal significand exponent wrong");
    p_sqrt_range_r3: assert (!(op_i == 3'd1 && in_normal) ||
                             ((out_exp == EXP_W'((1 << (EXP_W-1)) - 2) || out_exp == EXP_W'((1 << (EXP_W-1)) - 3))
                              && result_o[FRAC_W-1:0] == operand_i[FRAC_W-1:0]))
      else $error("square-root significand out of range");
    p_special_int_zero_r9: assert (!(is_int_o && !in_normal) || result_o == '0)
      else $error("integer result for non-normal input not zero");
    p_flush_r10: assert (!(!is_int_o && in_exp == '0) || result_o[DATA_W-2:0] == '0)
      else $error("subnormal not flushed");
  end

endmodule

bind fxs_unit fxs_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_fxs_unit_chk (
  .operand_i (operand_i),
  .op_i      (op_i),
  .result_o  (result_o),
  .is_int_o  (is_int_o)
);

// File: tb/test_fxs_unit.sv
module test_fxs_unit;

  logic        clk;
  logic        rst_n;
  logic [31:0] operand;
  logic [2:0]  op;
  logic [31:0] result;
  logic        is_int;

  int n_checks;
  int n_fail;
  bit done;

  fxs_unit i_fxs_unit (
    .operand_i (operand),
    .op_i      (op),
    .result_o  (result),
    .is_int_o  (is_int)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int floor_half(input int v);
    if (v >= 0) return v / 2;
    return -((1 - v) / 2);
  endfunction

  // Behavioural reference; returns result, sets kind flag and requirement tag
  function automatic logic [31:0] ref_model(input logic [31:0] x, input int code,
                                            output bit want_int, output string tag);
    int be, e, fh, iv;
    logic s;
    logic [22:0] fr;
    bit normal;
    s  = x[31];
    be = int'(x[30:23]);
    fr = x[22:0];
    want_int = (code >= 3);
    normal = (be != 0) && (be != 255);
    if (be == 0 && fr != 0) tag = "R10";
    else if (!normal)       tag = "R9";
    else begin
      case (code)
        0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R5";
        4: tag = "R6"; 5: tag = "R7"; 6: tag = "R8"; default: tag = "R1";
      endcase
    end
    if (code == 7) return 32'd0;
    if (!normal) begin
      if (want_int) return 32'd0;
      if (be == 0)  return {s, 31'd0};
      return x;
    end
    e  = be - 127;
    fh = floor_half(e);
    case (code)
      0: return {s, 8'd126, fr};
      1: return {s, ((e % 2) == 0) ? 8'd125 : 8'd126, fr};
      2: return {s, fr[22] ? 8'd126 : 8'd127, fr};
      3: iv = -e - 1;
      4: iv = fh + 1;
      5: iv = -fh - 1;
      default: iv = e + (fr[22] ? 1 : 0);
    endcase
    return iv;
  endfunction

  task automatic check_one(input logic [31:0] x, input int code);
    logic [31:0] exp_res;
    bit          exp_int;
    string       tag;
    exp_res = ref_model(x, code, exp_int, tag);
    @(negedge clk);
    operand = x;
    op      = 3'(code);
    #1;
    n_checks++;
    if (result !== exp_res) begin
      n_fail++;
      $display("FAIL %s op=%0d in=%h result actual=%h expected=%h", tag, code, x, result, exp_res);
    end
    n_checks++;
    if (is_int !== exp_int) begin
      n_fail++;
      $display("FAIL R1 op=%0d in=%h kind actual=%0b expected=%0b", code, x, is_int, exp_int);
    end
  endtask

  logic [31:0] corner [16];
  logic [31:0] lfsr;

  initial begin
    corner[0]  = 32'h3F80_0000; // 1.0, e=0 even
    corner[1]  = 32'h4040_0000; // 3.0, m=1.5 boundary
    corner[2]  = 32'h3FBF_FFFF; // just below 1.5
    corner[3]  = 32'hC0C0_0000; // -6.0, e=2
    corner[4]  = 32'h3E99_999A; // 0.3, e=-2
    corner[5]  = 32'h3F00_0000; // 0.5, e=-1 negative odd
    corner[6]  = 32'h3E00_0000; // e=-3
    corner[7]  = 32'h0080_0000; // min normal, e=-126
    corner[8]  = 32'h7F7F_FFFF; // max finite, e=127
    corner[9]  = 32'h0000_0001; // +subnormal
    corner[10] = 32'h807F_FFFF; // -subnormal
    corner[11] = 32'h0000_0000; // +0
    corner[12] = 32'h8000_0000; // -0
    corner[13] = 32'h7F80_0000; // +inf
    corner[14] = 32'hFF80_0000; // -inf
    corner[15] = 32'h7FC0_0001; // NaN
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    operand  = 32'd0;
    op       = 3'd0;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // initial state with zero operand (R9)
    check_one(32'd0, 0);
    for (int i = 0; i < 16; i++)
      for (int c = 0; c < 8; c++)
        check_one(corner[i], c);
    lfsr = 32'hACE1_2345;
    for (int k = 0; k < 300; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      check_one(lfsr, k % 8);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule